// File: doc/BRIEF.md
# Raster Blit Line Sequencer

This block runs a two-dimensional bit-block transfer over 16-bit memory words. It walks a rectangle of `yCount` lines, each `xCount` destination words wide. For every destination word it combines three inputs: a source word taken from a shifted two-word latch, a row of a 16-row halftone pattern, and the old destination word. It then writes the result back through a simple request/grant bus master port.

The sequencer reads memory only when the configuration needs it. A source read is issued only when the logic function and the halftone mode actually use the source. A destination read is issued only when the logic function uses the destination or when a partial edge mask forces a read-modify-write. Two per-line flags change how source words are fetched. One adds a priming source read at the start of each line. The other drops the final source read of each line. Because of this, a word costs one to three bus cycles.

Software sets the configuration inputs, pulses `start`, and keeps the configuration stable until `busy` falls.

Top module: `blit_engine`

## Requirements
- R1: Each destination word uses at most three bus accesses, each one clock long with `busStrobe` high, in the order source read (`busWe`=0), destination read (`busWe`=0), destination write (`busWe`=1); at most one access happens per clock.
- R2: The logic function depends on the source exactly when `logicOp[1:0]` differs from `logicOp[3:2]`. The halftone mode uses the source only when `htOp[1]`=1. A source read is issued only when both hold.
- R3: Halftone modes are: `htOp`=0 gives all ones, 1 gives the pattern row, 2 gives the shifted source, 3 gives the shifted source AND the pattern row. The pattern row is `htPattern[16*k +: 16]`, where k is the line number modulo 16 and the first line is 0. Reading the pattern costs no bus access.
- R4: Result bit = `logicOp[2*(1-s)+(1-d)]`, where s is the halftone-mode output bit and d is the old destination bit. A destination read happens whenever the function depends on d, i.e. `{logicOp[2],logicOp[0]}` differs from `{logicOp[3],logicOp[1]}`.
- R5: The edge mask is selected as follows: `headMask` for the first word of a line (also when `xCount`=1), `tailMask` for the last word, and `bodyMask` for the words between. A mask bit of 1 takes the result bit; a mask bit of 0 keeps the old destination bit. Any mask that is not all ones forces a destination read for that word.
- R6: Exactly `xCount` destination writes happen per line.
- R7: With `fxsr`=1 and the source in use, each line starts with one extra source read that has no matching write.
- R8: With `nfsr`=1 and the source in use, the source read for the last word of each line is skipped, except when `xCount`=1.
- R9: `busReq` is high while `busy` is high. No access happens before `busGrant` is seen. After the grant, one idle clock precedes the first access, and one idle clock follows the last access before `busy` falls. With `busGrant` already high, `busy` lasts accesses+3 clocks.
- R10: Each source read shifts the 32-bit latch left by one word and loads the new word into the lower half. The source word is bits [15:0] of the latch shifted right by `skew`. The latch is cleared at `start` and holds its value whenever no source read happens.
- R11: Addresses are word addresses in two's complement. The source address steps by `srcXinc` after each source read and by `srcYinc` at the end of each line. The destination address steps by `dstXinc` after each write and additionally by `dstYinc` at the end of each line.
- R12: After `yCount` lines, `busy` clears and `busReq` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-clock pulse that launches a transfer |
| srcStart | input | ADDR_W | First source word address |
| srcXinc | input | ADDR_W | Source step after each source read |
| srcYinc | input | ADDR_W | Source step at line end |
| dstStart | input | ADDR_W | First destination word address |
| dstXinc | input | ADDR_W | Destination step after each write |
| dstYinc | input | ADDR_W | Extra destination step at line end |
| xCount | input | CNT_W | Destination words per line (at least 1) |
| yCount | input | CNT_W | Number of lines (at least 1) |
| logicOp | input | 4 | Logic function truth table |
| htOp | input | 2 | Halftone mode |
| skew | input | $clog2(DATA_W) | Right shift applied to the source latch |
| fxsr | input | 1 | Priming source read per line |
| nfsr | input | 1 | Skip last source read per line |
| headMask | input | DATA_W | Mask for first word of a line |
| bodyMask | input | DATA_W | Mask for middle words |
| tailMask | input | DATA_W | Mask for last word |
| htPattern | input | HT_ROWS*DATA_W | Halftone pattern rows |
| busReq | output | 1 | Bus request |
| busGrant | input | 1 | Bus grant |
| busStrobe | output | 1 | Access in this clock |
| busWe | output | 1 | Access is a write |
| busAddr | output | ADDR_W | Access word address |
| busWdata | output | DATA_W | Write data |
| busRdata | input | DATA_W | Read data, sampled at the end of the access clock |
| busy | output | 1 | Transfer in progress |

## Verification
The bench sweeps every logic function and every halftone mode against partial and full masks, line widths of one to three words, and all four combinations of the priming and final-read flags. The expected final memory, the access count and the busy length come from an arithmetic model.

The single-word line with the final-read skip set is the key corner. A design that honoured the skip there would read one source word too few and write from a stale latch. A design that ignored a partial mask would overwrite protected destination bits and report one access too few. Mishandled priming or skipping would misalign every shifted word and change the per-line access count. A delayed grant checks that no access leaks out before arbitration.

// File: rtl/blit_pkg.sv
package blit_pkg;

  typedef enum logic [1:0] {
    MASK_HEAD = 2'd0,
    MASK_BODY = 2'd1,
    MASK_TAIL = 2'd2
  } maskSel_e;

  typedef struct packed {
    logic     load;
    logic     srcRead;
    logic     dstRead;
    logic     write;
    logic     lineEnd;
    maskSel_e maskSel;
  } blitCtl_t;

  // truth table index is {~s, ~d}
  function automatic logic opUsesSrc(input logic [3:0] op);
    return op[1:0] != op[3:2];
  endfunction

  function automatic logic opUsesDst(input logic [3:0] op);
    return {op[2], op[0]} != {op[3], op[1]};
  endfunction

endpackage

// File: rtl/blit_ctrl.sv
module blit_ctrl
  import blit_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [CNT_W-1:0]  xCount,
  input  logic [CNT_W-1:0]  yCount,
  input  logic [3:0]        logicOp,
  input  logic [1:0]        htOp,
  input  logic              fxsr,
  input  logic              nfsr,
  input  logic [DATA_W-1:0] headMask,
  input  logic [DATA_W-1:0] bodyMask,
  input  logic [DATA_W-1:0] tailMask,
  input  logic              busGrant,
  output logic              busReq,
  output logic              busStrobe,
  output logic              busWe,
  output logic              busy,
  output blitCtl_t          ctl
);

  typedef enum logic [2:0] {
    S_IDLE, S_WAITG, S_ARB, S_PRIME, S_SRC, S_DST, S_WR, S_REL
  } state_e;

  state_e           state, stateNext;
  logic [CNT_W-1:0] xLeft;
  logic [CNT_W-1:0] yLeft;
  logic             curFirst;
  logic             curLast;
  logic             srcUsed;
  logic             dstByOp;
  logic             singleWord;
  logic             needDstCur;
  state_e           lineStartState;

  assign srcUsed    = opUsesSrc(logicOp) && htOp[1];
  assign dstByOp    = opUsesDst(logicOp);
  assign singleWord = (xCount == CNT_W'(1));
  assign curLast    = (xLeft == CNT_W'(1));

  function automatic logic [DATA_W-1:0] maskFor(input logic isFirst, input logic isLast);
    if (isFirst)     return headMask;
    else if (isLast) return tailMask;
    else             return bodyMask;
  endfunction

  function automatic state_e wordEntry(input logic isFirst, input logic isLast);
    logic srcRd, dstRd;
    srcRd = srcUsed && !(nfsr && isLast && !singleWord);
    dstRd = dstByOp || (maskFor(isFirst, isLast) != {DATA_W{1'b1}});
    if (srcRd)      return S_SRC;
    else if (dstRd) return S_DST;
    else            return S_WR;
  endfunction

  assign needDstCur     = dstByOp || (maskFor(curFirst, curLast) != {DATA_W{1'b1}});
  assign lineStartState = (fxsr && srcUsed) ? S_PRIME : wordEntry(1'b1, singleWord);

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE:  if (start) stateNext = S_WAITG;
      S_WAITG: if (busGrant) stateNext = S_ARB;
      S_ARB:   stateNext = lineStartState;
      S_PRIME: stateNext = wordEntry(curFirst, curLast);
      S_SRC:   stateNext = needDstCur ? S_DST : S_WR;
      S_DST:   stateNext = S_WR;
      S_WR: begin
        if (curLast) stateNext = (yLeft == CNT_W'(1)) ? S_REL : lineStartState;
        else         stateNext = wordEntry(1'b0, xLeft == CNT_W'(2));
      end
      S_REL:   stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      xLeft    <= '0;
      yLeft    <= '0;
      curFirst <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == S_IDLE && start) begin
        xLeft    <= xCount;
        yLeft    <= yCount;
        curFirst <= 1'b1;
      end else if (state == S_WR) begin
        if (curLast) begin
          xLeft    <= xCount;
          yLeft    <= yLeft - CNT_W'(1);
          curFirst <= 1'b1;
        end else begin
          xLeft    <= xLeft - CNT_W'(1);
          curFirst <= 1'b0;
        end
      end
    end
  end

  assign busy      = (state != S_IDLE);
  assign busReq    = busy;
  assign busStrobe = (state == S_PRIME) || (state == S_SRC) || (state == S_DST) || (state == S_WR);
  assign busWe     = (state == S_WR);

  always_comb begin
    ctl         = '0;
    ctl.load    = (state == S_IDLE) && start;
    ctl.srcRead = (state == S_PRIME) || (state == S_SRC);
    ctl.dstRead = (state == S_DST);
    ctl.write   = (state == S_WR);
    ctl.lineEnd = (state == S_WR) && curLast;
    ctl.maskSel = curFirst ? MASK_HEAD : (curLast ? MASK_TAIL : MASK_BODY);
  end

  // writes seen in the current line, used by the line-width check
  logic [CNT_W-1:0] wrInLine;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      wrInLine <= '0;
    else if (ctl.load || ctl.lineEnd) wrInLine <= '0;
    else if (ctl.write)             wrInLine <= wrInLine + CNT_W'(1);
  end

  p_single_access_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.srcRead, ctl.dstRead, ctl.write}));

  p_dst_then_write_r1: assert property (@(posedge clk) disable iff (!rstN)
    ctl.dstRead |=> ctl.write);

  p_line_writes_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.lineEnd |-> (wrInLine == xCount - CNT_W'(1)));

  p_tail_skip_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.write && ctl.maskSel == MASK_TAIL && nfsr && !singleWord) |-> !$past(ctl.srcRead));

  p_wait_grant_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAITG && !busGrant) |=> !busStrobe);

  p_release_gap_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !$past(busStrobe));

endmodule

// File: rtl/blit_datapath.sv
module blit_datapath
  import blit_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int HT_ROWS = 16,
  localparam int SKEW_W = $clog2(DATA_W),
  localparam int LINE_W = $clog2(HT_ROWS)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  blitCtl_t                  ctl,
  input  logic [ADDR_W-1:0]         srcStart,
  input  logic [ADDR_W-1:0]         srcXinc,
  input  logic [ADDR_W-1:0]         srcYinc,
  input  logic [ADDR_W-1:0]         dstStart,
  input  logic [ADDR_W-1:0]         dstXinc,
  input  logic [ADDR_W-1:0]         dstYinc,
  input  logic [3:0]                logicOp,
  input  logic [1:0]                htOp,
  input  logic [SKEW_W-1:0]         skew,
  input  logic [DATA_W-1:0]         headMask,
  input  logic [DATA_W-1:0]         bodyMask,
  input  logic [DATA_W-1:0]         tailMask,
  input  logic [HT_ROWS*DATA_W-1:0] htPattern,
  input  logic [DATA_W-1:0]         busRdata,
  output logic [ADDR_W-1:0]         busAddr,
  output logic [DATA_W-1:0]         busWdata
);

  logic [ADDR_W-1:0]   srcAddr, dstAddr;
  logic [2*DATA_W-1:0] srcLatch;
  logic [2*DATA_W-1:0] shifted;
  logic [DATA_W-1:0]   dstData;
  logic [LINE_W-1:0]   lineIdx;
  logic [DATA_W-1:0]   srcWord, htWord, hopOut, opOut, maskWord;

  assign shifted = srcLatch >> skew;
  assign srcWord = shifted[DATA_W-1:0];
  assign htWord  = htPattern[lineIdx*DATA_W +: DATA_W];

  always_comb begin
    unique case (htOp)
      2'd0: hopOut = {DATA_W{1'b1}};
      2'd1: hopOut = htWord;
      2'd2: hopOut = srcWord;
      default: hopOut = srcWord & htWord;
    endcase
  end

  for (genvar b = 0; b < DATA_W; b++) begin : g_opBit
    assign opOut[b] = logicOp[{~hopOut[b], ~dstData[b]}];
  end

  always_comb begin
    unique case (ctl.maskSel)
      MASK_HEAD: maskWord = headMask;
      MASK_TAIL: maskWord = tailMask;
      default:   maskWord = bodyMask;
    endcase
  end

  assign busWdata = (opOut & maskWord) | (dstData & ~maskWord);
  assign busAddr  = ctl.srcRead ? srcAddr : dstAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcAddr  <= '0;
      dstAddr  <= '0;
      srcLatch <= '0;
      dstData  <= '0;
      lineIdx  <= '0;
    end else if (ctl.load) begin
      srcAddr  <= srcStart;
      dstAddr  <= dstStart;
      srcLatch <= '0;
      lineIdx  <= '0;
    end else begin
      if (ctl.srcRead) begin
        srcLatch <= {srcLatch[DATA_W-1:0], busRdata};
        srcAddr  <= srcAddr + srcXinc;
      end else if (ctl.lineEnd) begin
        srcAddr  <= srcAddr + srcYinc;
      end
      if (ctl.dstRead) dstData <= busRdata;
      if (ctl.write)
        dstAddr <= dstAddr + dstXinc + (ctl.lineEnd ? dstYinc : '0);
      if (ctl.lineEnd) lineIdx <= lineIdx + LINE_W'(1);
    end
  end

  p_latch_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.srcRead && !ctl.load) |=> $stable(srcLatch));

endmodule

// File: rtl/blit_engine.sv
module blit_engine
  import blit_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 8,
  parameter int HT_ROWS = 16,
  localparam int SKEW_W = $clog2(DATA_W)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      start,
  input  logic [ADDR_W-1:0]         srcStart,
  input  logic [ADDR_W-1:0]         srcXinc,
  input  logic [ADDR_W-1:0]         srcYinc,
  input  logic [ADDR_W-1:0]         dstStart,
  input  logic [ADDR_W-1:0]         dstXinc,
  input  logic [ADDR_W-1:0]         dstYinc,
  input  logic [CNT_W-1:0]          xCount,
  input  logic [CNT_W-1:0]          yCount,
  input  logic [3:0]                logicOp,
  input  logic [1:0]                htOp,
  input  logic [SKEW_W-1:0]         skew,
  input  logic                      fxsr,
  input  logic                      nfsr,
  input  logic [DATA_W-1:0]         headMask,
  input  logic [DATA_W-1:0]         bodyMask,
  input  logic [DATA_W-1:0]         tailMask,
  input  logic [HT_ROWS*DATA_W-1:0] htPattern,
  output logic                      busReq,
  input  logic                      busGrant,
  output logic                      busStrobe,
  output logic                      busWe,
  output logic [ADDR_W-1:0]         busAddr,
  output logic [DATA_W-1:0]         busWdata,
  input  logic [DATA_W-1:0]         busRdata,
  output logic                      busy
);

  blitCtl_t ctl;

  blit_ctrl #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .xCount(xCount), .yCount(yCount),
    .logicOp(logicOp), .htOp(htOp), .fxsr(fxsr), .nfsr(nfsr),
    .headMask(headMask), .bodyMask(bodyMask), .tailMask(tailMask),
    .busGrant(busGrant), .busReq(busReq), .busStrobe(busStrobe),
    .busWe(busWe), .busy(busy), .ctl(ctl)
  );

  blit_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HT_ROWS(HT_ROWS)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .srcStart(srcStart), .srcXinc(srcXinc), .srcYinc(srcYinc),
    .dstStart(dstStart), .dstXinc(dstXinc), .dstYinc(dstYinc),
    .logicOp(logicOp), .htOp(htOp), .skew(skew),
    .headMask(headMask), .bodyMask(bodyMask), .tailMask(tailMask),
    .htPattern(htPattern), .busRdata(busRdata),
    .busAddr(busAddr), .busWdata(busWdata)
  );

endmodule

// File: tb/blit_engine_test.sv
module blit_engine_test;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [15:0]  srcStart = '0, srcXinc = '0, srcYinc = '0;
  logic [15:0]  dstStart = '0, dstXinc = '0, dstYinc = '0;
  logic [7:0]   xCount = 8'd1, yCount = 8'd1;
  logic [3:0]   logicOp = '0;
  logic [1:0]   htOp = '0;
  logic [3:0]   skew = '0;
  logic         fxsr = 1'b0, nfsr = 1'b0;
  logic [15:0]  headMask = '1, bodyMask = '1, tailMask = '1;
  logic [255:0] htPattern;
  logic         busReq, busGrant, busStrobe, busWe, busy;
  logic [15:0]  busAddr, busWdata, busRdata;

  logic [15:0]  mem [256];
  logic [15:0]  expMem [256];

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  blit_engine uut (
    .clk(clk), .rstN(rstN), .start(start),
    .srcStart(srcStart), .srcXinc(srcXinc), .srcYinc(srcYinc),
    .dstStart(dstStart), .dstXinc(dstXinc), .dstYinc(dstYinc),
    .xCount(xCount), .yCount(yCount), .logicOp(logicOp), .htOp(htOp),
    .skew(skew), .fxsr(fxsr), .nfsr(nfsr),
    .headMask(headMask), .bodyMask(bodyMask), .tailMask(tailMask),
    .htPattern(htPattern), .busReq(busReq), .busGrant(busGrant),
    .busStrobe(busStrobe), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busy(busy)
  );

  assign busRdata = mem[busAddr[7:0]];
  always @(posedge clk) if (busStrobe && busWe) mem[busAddr[7:0]] <= busWdata;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // arithmetic model of one transfer; updates expMem, returns expected counts
  task automatic model(input int gd, output int eAcc, output int eWr, output int eCyc);
    logic [31:0] lat;
    logic [7:0]  sa, da;
    logic [15:0] mk, sw, hw, hv, d, r;
    bit          sUse, dUse, last;
    lat = '0; sa = srcStart[7:0]; da = dstStart[7:0];
    eAcc = 0; eWr = 0;
    sUse = (logicOp[1:0] != logicOp[3:2]) && htOp[1];
    dUse = ({logicOp[2], logicOp[0]} != {logicOp[3], logicOp[1]});
    for (int y = 0; y < int'(yCount); y++) begin
      hw = htPattern[(y % 16)*16 +: 16];
      if (fxsr && sUse) begin
        lat = {lat[15:0], expMem[sa]}; sa = sa + srcXinc[7:0]; eAcc++;
      end
      for (int x = 0; x < int'(xCount); x++) begin
        last = (x == int'(xCount) - 1);
        mk = (x == 0) ? headMask : (last ? tailMask : bodyMask);
        if (sUse && !(nfsr && last && xCount != 8'd1)) begin
          lat = {lat[15:0], expMem[sa]}; sa = sa + srcXinc[7:0]; eAcc++;
        end
        if (dUse || mk != 16'hFFFF) eAcc++;
        sw = 16'(lat >> skew);
        case (htOp)
          2'd0: hv = 16'hFFFF;
          2'd1: hv = hw;
          2'd2: hv = sw;
          default: hv = sw & hw;
        endcase
        d = expMem[da];
        for (int b = 0; b < 16; b++) r[b] = logicOp[{~hv[b], ~d[b]}];
        expMem[da] = (r & mk) | (d & ~mk);
        da = da + dstXinc[7:0];
        eAcc++; eWr++;
      end
      sa = sa + srcYinc[7:0];
      da = da + dstYinc[7:0];
    end
    eCyc = eAcc + 2 + ((gd > 1) ? gd : 1);
  endtask

  task automatic runOne(input int gd, input int seed);
    int eAcc, eWr, eCyc, acc, wr, cyc, early, bad;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 16'(i * 16'h9E37) ^ 16'(seed * 16'h3B1D);
      expMem[i] = mem[i];
    end
    model(gd, eAcc, eWr, eCyc);
    acc = 0; wr = 0; cyc = 0; early = 0;
    @(negedge clk);
    busGrant = (gd == 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy && cyc < 400) begin
      cyc++;
      if (busStrobe) acc++;
      if (busStrobe && busWe) wr++;
      if (cyc <= gd && busStrobe) early++;
      if (cyc == gd) busGrant = 1'b1;
      @(negedge clk);
    end
    bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== expMem[i]) bad++;
    check(bad == 0, "R3 R4 R5 R10 R11 memory words differing", bad, 0);
    check(acc == eAcc, "R1 R2 R7 R8 access count", acc, eAcc);
    check(wr == eWr, "R6 R12 write count", wr, eWr);
    check(cyc == eCyc, "R9 R12 busy clocks", cyc, eCyc);
    if (gd > 0) check(early == 0, "R9 accesses before grant", early, 0);
    check(!busReq, "R12 request dropped", busReq, 0);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int seed;
    for (int r = 0; r < 16; r++) htPattern[r*16 +: 16] = 16'(r * 16'h1111) ^ 16'hA5C3;
    busGrant = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy && !busReq && !busStrobe, "R9 reset outputs idle", busy, 0);
    rstN = 1'b1;
    srcStart = 16'h0010; srcXinc = 16'd1; srcYinc = 16'd3;
    dstStart = 16'h0080; dstXinc = 16'd1; dstYinc = 16'hFFFE + 16'd4;
    yCount = 8'd2;
    seed = 0;
    for (int op = 0; op < 16; op++)
      for (int hop = 0; hop < 4; hop++)
        for (int mm = 0; mm < 2; mm++)
          for (int xc = 1; xc <= 3; xc++)
            for (int fl = 0; fl < 4; fl++) begin
              logicOp = 4'(op); htOp = 2'(hop);
              xCount = 8'(xc);
              fxsr = fl[0]; nfsr = fl[1];
              skew = 4'((op * 3 + hop * 5 + xc) % 16);
              if (mm == 0) begin
                headMask = 16'hFFFF; bodyMask = 16'hFFFF; tailMask = 16'hFFFF;
              end else begin
                headMask = 16'h0FF0; bodyMask = 16'h3C3C; tailMask = 16'hF00F;
              end
              seed++;
              runOne(0, seed);
            end
    // delayed grant, longer line, more lines than pattern rows wrap
    logicOp = 4'd3; htOp = 2'd3; xCount = 8'd4; yCount = 8'd18;
    fxsr = 1'b1; nfsr = 1'b1; skew = 4'd7;
    headMask = 16'h00FF; bodyMask = 16'hFFFF; tailMask = 16'hFF00;
    srcYinc = 16'hFFFF; dstYinc = 16'd3;
    runOne(5, 77);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule